// File: doc/BRIEF.md
# EEPROM Write Protection Sequencer

This block is the control side of a byte-wide data EEPROM port. A CPU loads an address register and a data register, then either pulses a read strobe, which copies the addressed byte into the data register in the next cycle, or performs a guarded write. To write, the CPU first sets a master enable. That enable arms for a short fixed window and then disarms by itself. A write strobe that arrives inside the window starts a self-timed write. A strobe that arrives outside the window does nothing.

While a write is running, the busy flag stays high and the address register is frozen. Read strobes are dropped during this time. Every accepted access stalls the CPU for a fixed number of cycles. A level-type ready interrupt is raised whenever it is enabled and no write is running. An input from the flash self-programming engine blocks any new write for as long as it is high. The storage is an internal memory model that comes out of reset filled with 0xFF.

Top module: `ee_write_seq`

## Requirements
- R1: A cycle with `arm_we` high sets `armed` on the next edge. `armed` then stays high for exactly ARM_WIN (4) cycles and falls by itself. A new `arm_we` restarts the window.
- R2: `wstrobe_set` starts a write only when `armed` is high at that edge. Outside the window, the strobe leaves `wbusy`, the memory and all other outputs unchanged.
- R3: An accepted write stores `data_q` at `addr_q`. `wbusy` then stays high for exactly WR_CYC (32) cycles and clears by itself. A strobe while `wbusy` is high is ignored.
- R4: While `wbusy` is high, `rstrobe` is ignored, so `data_q` does not change because of it, and `addr_we` is ignored, so `addr_q` holds. This also applies on the edge that launches a write.
- R5: No write starts on an edge where `flash_busy` is high, even when `armed` is high.
- R6: An accepted read loads `mem[addr_q]` into `data_q` on the same edge. `cpu_hold` is then high for RD_HOLD (4) cycles. A read takes priority over `data_we` in the same cycle.
- R7: A write launch raises `cpu_hold` for WR_HOLD (2) cycles.
- R8: `rdy_irq` is high exactly when `rdy_ie` is high and `wbusy` is low.
- R9: After reset, `addr_q` and `data_q` are 0, all flags are low, and every memory byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_we | input | 1 | Load address register |
| addr_in | input | 9 | New address |
| data_we | input | 1 | Load data register |
| data_in | input | 8 | New data |
| arm_we | input | 1 | Write one to the master write enable |
| wstrobe_set | input | 1 | Set the write strobe |
| rstrobe | input | 1 | Read strobe |
| rdy_ie | input | 1 | Ready interrupt enable |
| flash_busy | input | 1 | Flash self-programming in progress |
| addr_q | output | 9 | Address register |
| data_q | output | 8 | Data register / read result |
| armed | output | 1 | Master write enable, still armed |
| wbusy | output | 1 | Write strobe, high while a write runs |
| cpu_hold | output | 1 | CPU stall request |
| rdy_irq | output | 1 | Ready interrupt request (level) |

## Verification
The hardest cases sit at the edges of the timing windows. One is a write strobe on the last armed cycle compared with one a single cycle later. Another is a collision in which the arm window, `flash_busy` and an ongoing write overlap, together with read and address strokes that land inside the write. The stimulus places strobes at offsets of 3, 4 and 5 cycles after arming and re-arms partway through a window. It raises `flash_busy` during an armed window, then drops it while the window is still open. It also fires reads and address loads during the write and on the launch edge itself. A behavioural model follows every edge, and reads at addresses 0, 511 and the written locations confirm which writes actually reached the memory.

// File: rtl/ee_write_seq.sv
module ee_write_seq #(
  parameter int AW      = 9,
  parameter int DW      = 8,
  parameter int WR_CYC  = 32,
  parameter int ARM_WIN = 4,
  parameter int RD_HOLD = 4,
  parameter int WR_HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_in,
  input  logic          data_we,
  input  logic [DW-1:0] data_in,
  input  logic          arm_we,
  input  logic          wstrobe_set,
  input  logic          rstrobe,
  input  logic          rdy_ie,
  input  logic          flash_busy,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          armed,
  output logic          wbusy,
  output logic          cpu_hold,
  output logic          rdy_irq
);
  localparam int DEPTH = 1 << AW;
  localparam int HMAX  = (RD_HOLD > WR_HOLD) ? RD_HOLD : WR_HOLD;
  localparam int ACW   = $clog2(ARM_WIN + 1);
  localparam int WCW   = $clog2(WR_CYC + 1);
  localparam int HCW   = $clog2(HMAX + 1);

  logic [DW-1:0]  mem [DEPTH];
  logic [ACW-1:0] arm_cnt;
  logic [WCW-1:0] wr_cnt;
  logic [HCW-1:0] hold_cnt;
  logic           launch, rd_go;

  assign armed    = arm_cnt != '0;
  assign wbusy    = wr_cnt != '0;
  assign cpu_hold = hold_cnt != '0;
  assign rdy_irq  = rdy_ie & ~wbusy;
  assign launch   = wstrobe_set & armed & ~wbusy & ~flash_busy;
  assign rd_go    = rstrobe & ~wbusy & ~launch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (launch) begin
      mem[addr_q] <= data_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_cnt  <= '0;
      wr_cnt   <= '0;
      hold_cnt <= '0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      if (arm_we)             arm_cnt <= ACW'(ARM_WIN);
      else if (armed)         arm_cnt <= arm_cnt - 1'b1;

      if (launch)             wr_cnt <= WCW'(WR_CYC);
      else if (wbusy)         wr_cnt <= wr_cnt - 1'b1;

      if (rd_go)              hold_cnt <= HCW'(RD_HOLD);
      else if (launch)        hold_cnt <= HCW'(WR_HOLD);
      else if (cpu_hold)      hold_cnt <= hold_cnt - 1'b1;

      if (addr_we && !wbusy && !launch) addr_q <= addr_in;

      if (rd_go)              data_q <= mem[addr_q];
      else if (data_we)       data_q <= data_in;
    end
  end
endmodule

// File: rtl/ee_write_seq_chk.sv
module ee_write_seq_chk #(
  parameter int AW      = 9,
  parameter int DW      = 8,
  parameter int WR_CYC  = 32,
  parameter int ARM_WIN = 4,
  parameter int RD_HOLD = 4,
  parameter int WR_HOLD = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_we,
  input logic          arm_we,
  input logic          wstrobe_set,
  input logic          rdy_ie,
  input logic          flash_busy,
  input logic [AW-1:0] addr_q,
  input logic          armed,
  input logic          wbusy,
  input logic          cpu_hold,
  input logic          rdy_irq
);
  int arm_age;
  int busy_age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_age  <= ARM_WIN;
      busy_age <= 0;
    end else begin
      if (arm_we)                 arm_age <= 0;
      else if (arm_age < ARM_WIN) arm_age <= arm_age + 1;
      busy_age <= wbusy ? busy_age + 1 : 0;
    end
  end

  assert_arm_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> arm_age < ARM_WIN);
  assert_arm_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    arm_we |=> armed);
  assert_launch_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wbusy) |-> $past(armed) && $past(wstrobe_set));
  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wbusy) |-> $past(busy_age) == WR_CYC - 1);
  assert_busy_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wbusy |-> busy_age < WR_CYC);
  assert_addr_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wbusy |-> $stable(addr_q));
  assert_flash_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wbusy) |-> !$past(flash_busy));
  assert_launch_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wbusy) |-> cpu_hold);
  assert_irq_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wbusy) && rdy_ie) |-> rdy_irq);
endmodule

bind ee_write_seq ee_write_seq_chk #(
  .AW(AW), .DW(DW), .WR_CYC(WR_CYC), .ARM_WIN(ARM_WIN),
  .RD_HOLD(RD_HOLD), .WR_HOLD(WR_HOLD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .arm_we(arm_we),
  .wstrobe_set(wstrobe_set), .rdy_ie(rdy_ie), .flash_busy(flash_busy),
  .addr_q(addr_q), .armed(armed), .wbusy(wbusy), .cpu_hold(cpu_hold),
  .rdy_irq(rdy_irq)
);

// File: tb/tb_ee_write_seq.sv
module tb_ee_write_seq;
  localparam int WR = 32;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       addr_we = 0, data_we = 0, arm_we = 0, wstrobe_set = 0;
  logic       rstrobe = 0, rdy_ie = 0, flash_busy = 0;
  logic [8:0] addr_in = '0;
  logic [7:0] data_in = '0;
  logic [8:0] addr_q;
  logic [7:0] data_q;
  logic       armed, wbusy, cpu_hold, rdy_irq;

  ee_write_seq dut (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_in(addr_in),
    .data_we(data_we), .data_in(data_in), .arm_we(arm_we),
    .wstrobe_set(wstrobe_set), .rstrobe(rstrobe), .rdy_ie(rdy_ie),
    .flash_busy(flash_busy), .addr_q(addr_q), .data_q(data_q),
    .armed(armed), .wbusy(wbusy), .cpu_hold(cpu_hold), .rdy_irq(rdy_irq)
  );

  always #5 clk = ~clk;

  // behavioural reference
  logic [7:0] m_mem [512];
  int         m_arm, m_busy, m_hold;
  logic [8:0] m_addr;
  logic [7:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_arm = 0; m_busy = 0; m_hold = 0; m_addr = 0; m_data = 0;
    end else begin
      bit go_w, go_r, was_busy;
      was_busy = m_busy > 0;
      go_w = wstrobe_set && m_arm > 0 && !was_busy && !flash_busy;
      go_r = rstrobe && !was_busy && !go_w;
      if (go_w) m_mem[m_addr] = m_data;
      if (go_r) m_data = m_mem[m_addr];
      else if (data_we) m_data = data_in;
      if (addr_we && !was_busy && !go_w) m_addr = addr_in;
      if (go_w) m_busy = WR; else if (m_busy > 0) m_busy--;
      if (go_r) m_hold = 4; else if (go_w) m_hold = 2; else if (m_hold > 0) m_hold--;
      if (arm_we) m_arm = 4; else if (m_arm > 0) m_arm--;
    end
  end

  int vecs = 0, errs = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    vecs++;
    chk("R1 armed", armed, m_arm > 0);
    chk("R3 wbusy (R2/R5 launch gating)", wbusy, m_busy > 0);
    chk("R4 addr_q", addr_q, m_addr);
    chk("R6 data_q", data_q, m_data);
    chk("R6 or R7 cpu_hold", cpu_hold, m_hold > 0);
    chk("R8 rdy_irq", rdy_irq, rdy_ie && m_busy == 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic set_addr(int a);
    addr_we = 1; addr_in = 9'(a); cyc(); addr_we = 0;
  endtask

  task automatic set_data(int d);
    data_we = 1; data_in = 8'(d); cyc(); data_we = 0;
  endtask

  task automatic rd();
    rstrobe = 1; cyc(); rstrobe = 0;
  endtask

  task automatic arm();
    arm_we = 1; cyc(); arm_we = 0;
  endtask

  task automatic strobe();
    wstrobe_set = 1; cyc(); wstrobe_set = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle(2);
    @(negedge clk); rst_n = 1;
    idle(1);                              // R9 reset state
    rdy_ie = 1;
    set_addr(5); rd(); idle(4);           // R9 erased byte, R6 hold
    set_addr(511); rd(); idle(1);
    set_addr(10); set_data(8'h3C);
    strobe(); idle(3);                    // R2 no arm -> ignored
    rd(); idle(4);
    set_data(8'hA5);
    arm(); idle(3); strobe();             // R1 window last cycle -> write
    rstrobe = 1; idle(3); rstrobe = 0;    // R4 reads ignored while busy
    set_addr(99); strobe();               // R3 strobe ignored while busy
    idle(WR);                             // R8 irq back
    rd(); idle(4);                        // R3 stored value
    set_addr(20); set_data(8'h11);
    arm(); idle(4); strobe(); idle(3);    // R1 expired -> ignored
    set_addr(20); rd(); idle(4);
    set_data(8'h77);
    arm(); idle(2); arm(); idle(3); strobe(); // R1 re-arm extends
    idle(WR + 2);
    set_addr(0); set_data(8'h42);
    flash_busy = 1; arm(); strobe(); idle(1); // R5 blocked
    flash_busy = 0; strobe();             // R5 released inside window
    idle(1);
    addr_we = 1; addr_in = 9'd300; rstrobe = 1; idle(2);
    addr_we = 0; rstrobe = 0;             // R4 address frozen
    idle(WR);
    set_addr(0); data_we = 1; data_in = 8'h99; rstrobe = 1; cyc();
    data_we = 0; rstrobe = 0; idle(4);    // R6 read beats data write
    set_addr(20); rd(); idle(1);
    set_addr(10); rd(); idle(1);
    set_data(8'h5A); set_addr(511);
    arm(); addr_we = 1; addr_in = 9'd7; rstrobe = 1; wstrobe_set = 1; cyc();
    addr_we = 0; rstrobe = 0; wstrobe_set = 0;  // R4 launch edge, R7 hold
    rdy_ie = 0; idle(WR + 2); rdy_ie = 1;
    rd(); idle(4);
    finish_run();
  end
endmodule